// File: doc/BRIEF.md
# Shared Semaphore Cluster with Stall Watchdog

This block is one synchronization cluster shared by four processors. It keeps a bank of 32 one-bit semaphores, organised as eight groups of four. Each processor has its own request port. On it, the processor asks for one of three operations on a single semaphore: test-and-set, unconditional set, or clear. The semaphore is named either by an immediate group and bit field, or by an index value the processor supplies from one of its local registers. A test-and-set that finds its semaphore already set does not fail. The processor stays stalled in hardware and retries every cycle, and it completes as soon as another processor clears the bit.

A cluster-wide watchdog looks at every processor marked active. If all of them are stalled at once, no one is left to release a semaphore. What the watchdog does then depends on a four-bit switch mask, one bit per processor. With the mask all zero it raises a deadlock interrupt to every processor, and that interrupt stays up until it is acknowledged. With any mask bit set it raises a task-switch request instead, because a parked task elsewhere in the cluster could still make progress.

Per-port states are IDLE and WAIT. IDLE→WAIT happens on a test-and-set that loses. WAIT→IDLE happens on the cycle the retry wins. IDLE→IDLE happens on any completed set, clear or winning test-and-set. Watchdog states are SCAN, HALT (deadlock interrupt) and YIELD (switch request). SCAN→HALT when all are stalled and the mask is zero. SCAN→YIELD when all are stalled and the mask is nonzero. HALT→SCAN on acknowledge. YIELD→SCAN when the all-stalled condition ends. YIELD→HALT when the mask becomes zero while the condition holds.

Top module: `semc_cluster`

## Requirements
- R1: After reset all 32 semaphores are clear. Semaphore g*4+b (group g 0..7, bit b 0..3) is visible at `sem_state[g*4+b]`. A direct request names it with `req_group`=g and `req_bit`=b.
- R2: With `req_indirect`=1 the semaphore number is the low 5 bits of the 8-bit `req_index`. Higher index bits are ignored.
- R3: Operation codes on `req_op` are 00 none, 01 test-and-set, 10 set, 11 clear. A set or clear from an idle active port takes effect at the next clock edge, and `op_done` pulses high for exactly the following cycle.
- R4: A test-and-set on a clear semaphore sets it at the next edge, pulses `op_done`, and leaves `stalled` low.
- R5: A test-and-set on a set semaphore raises `stalled` from the next edge and gives no `op_done`. It keeps retrying the same semaphore. In the cycle another port clears the bit, the retry wins: the bit stays set, `op_done` pulses and `stalled` drops at the following edge.
- R6: When several ports test-and-set the same clear semaphore in one cycle (new requests or pending retries), only the lowest-numbered port wins. The others stall.
- R7: Within one cycle, clears apply first, then sets, then test-and-sets. A clear and a test-and-set on the same bit let the test-and-set win. A set and a test-and-set on the same bit make it stall. A set and a clear on the same bit leave it set.
- R8: Requests from a port whose `cpu_active` bit is low are ignored: no semaphore change, no `op_done`. Inactive ports are left out of the all-stalled condition, which also needs at least one active port.
- R9: New requests arriving at a stalled port are ignored until its pending test-and-set completes.
- R10: When every active port is stalled and `switch_mask` is zero, `deadlock_irq` rises at the clock edge after the stalls are visible. It stays high, whatever the mask does, until `deadlock_ack` is sampled high.
- R11: When every active port is stalled and `switch_mask` is nonzero, `switch_req` rises at the next edge instead. It falls once the condition ends and hands over to `deadlock_irq` if the mask becomes zero. The two outputs are never high together.
- R12: An acknowledge drops `deadlock_irq` at the next edge. If the all-stalled condition still holds, the watchdog re-raises the interrupt or switch request one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_active | input | 4 | Per-port active flag |
| req_valid | input | 4 | Per-port request strobe, one cycle per request |
| req_op | input | 8 | Per-port operation code, 2 bits each |
| req_indirect | input | 4 | Per-port select of indexed addressing |
| req_group | input | 12 | Per-port direct group number, 3 bits each |
| req_bit | input | 8 | Per-port direct bit number, 2 bits each |
| req_index | input | 32 | Per-port index value, 8 bits each |
| switch_mask | input | 4 | One bit per processor; nonzero means a task switch is possible |
| deadlock_ack | input | 1 | Acknowledge of the deadlock interrupt |
| op_done | output | 4 | Per-port completion pulse |
| stalled | output | 4 | Per-port pending test-and-set |
| sem_state | output | 32 | Current value of every semaphore |
| deadlock_irq | output | 1 | Deadlock interrupt to all processors |
| switch_req | output | 1 | Cluster task-switch request |

## Verification
The assertions assume the following about the inputs. A request strobe is a single-cycle pulse. `deadlock_ack` matters only while the interrupt is up. The index is wider than the semaphore number, so the modulo case can arise at all. The stimulus is driven only on falling edges, one cycle per request. It deliberately sends requests to stalled and inactive ports, and it puts conflicting operations on one semaphore in the same cycle, so that each ordering rule is exercised. The watchdog is driven into each of its states by parking every active port on a semaphore held by another. The mask and acknowledge are then toggled while the ports stay stalled.

// File: rtl/semc_pkg.sv
package semc_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_TAS  = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } sem_op_e;

    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_WAIT = 1'b1
    } port_state_e;

    typedef enum logic [1:0] {
        WD_SCAN  = 2'd0,
        WD_HALT  = 2'd1,
        WD_YIELD = 2'd2
    } watch_state_e;

endpackage

// File: rtl/semc_port.sv
module semc_port
    import semc_pkg::*;
#(
    parameter int GRP_W  = 3,
    parameter int BIT_W  = 2,
    parameter int IDX_W  = 8,
    localparam int ADDR_W = GRP_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_indirect,
    input  logic [GRP_W-1:0]  req_group,
    input  logic [BIT_W-1:0]  req_bit,
    input  logic [IDX_W-1:0]  req_index,
    input  logic              grant,
    output logic              want_tas,
    output logic              want_set,
    output logic              want_clr,
    output logic [ADDR_W-1:0] addr,
    output logic              stalled,
    output logic              op_done
);

    port_state_e       state_q, state_d;
    logic [ADDR_W-1:0] pend_q;
    logic [ADDR_W-1:0] dec_addr;
    logic              done_q;
    logic              complete;
    logic              new_req;
    sem_op_e           op;

    if (IDX_W > ADDR_W) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^req_index[IDX_W-1:ADDR_W];
    end

    // request decode: direct group/bit or low bits of the index
    always_comb begin
        op       = sem_op_e'(req_op);
        new_req  = req_valid && active && (state_q == PORT_IDLE);
        dec_addr = req_indirect ? req_index[ADDR_W-1:0] : {req_group, req_bit};
    end

    // next-state logic
    always_comb begin
        state_d  = state_q;
        complete = 1'b0;
        unique case (state_q)
            PORT_IDLE: begin
                if (new_req) begin
                    unique case (op)
                        OP_NONE: complete = 1'b0;
                        OP_SET,
                        OP_CLR:  complete = 1'b1;
                        OP_TAS: begin
                            if (grant) complete = 1'b1;
                            else       state_d  = PORT_WAIT;
                        end
                    endcase
                end
            end
            PORT_WAIT: begin
                if (grant) begin
                    complete = 1'b1;
                    state_d  = PORT_IDLE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PORT_IDLE;
            pend_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= complete;
            if (state_q == PORT_IDLE && state_d == PORT_WAIT)
                pend_q <= dec_addr;
        end
    end

    // outputs
    always_comb begin
        addr     = (state_q == PORT_WAIT) ? pend_q : dec_addr;
        want_tas = (state_q == PORT_WAIT) || (new_req && op == OP_TAS);
        want_set = new_req && (op == OP_SET);
        want_clr = new_req && (op == OP_CLR);
        stalled  = (state_q == PORT_WAIT);
        op_done  = done_q;
    end

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && !grant) |=> (stalled && !op_done));

    // R9
    pend_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && !grant) |=> (addr == $past(addr)));

    // R8
    inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !stalled) |=> !op_done);

    // R3
    setclr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (want_set || want_clr) |=> (op_done && !stalled));

endmodule

// File: rtl/semc_bank.sv
module semc_bank #(
    parameter int N_CPU  = 4,
    parameter int ADDR_W = 5,
    localparam int N_SEM = 1 << ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CPU-1:0]          want_tas,
    input  logic [N_CPU-1:0]          want_set,
    input  logic [N_CPU-1:0]          want_clr,
    input  logic [N_CPU*ADDR_W-1:0]   addr_flat,
    output logic [N_CPU-1:0]          grant,
    output logic [N_SEM-1:0]          sem_q
);

    logic [ADDR_W-1:0] addr_a [N_CPU];
    logic [N_SEM-1:0]  after_clr, after_set, claim;

    for (genvar c = 0; c < N_CPU; c++) begin : g_addr
        assign addr_a[c] = addr_flat[c*ADDR_W +: ADDR_W];
    end

    // clears first, then sets, then test-and-set in port-number order
    always_comb begin
        after_clr = sem_q;
        for (int c = 0; c < N_CPU; c++)
            if (want_clr[c]) after_clr[addr_a[c]] = 1'b0;
        after_set = after_clr;
        for (int c = 0; c < N_CPU; c++)
            if (want_set[c]) after_set[addr_a[c]] = 1'b1;
        claim = after_set;
        grant = '0;
        for (int c = 0; c < N_CPU; c++) begin
            if (want_tas[c] && !claim[addr_a[c]]) begin
                grant[c]           = 1'b1;
                claim[addr_a[c]]   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sem_q <= '0;
        else        sem_q <= claim;
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_chk
        // R4
        grant_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[c] |=> sem_q[$past(addr_a[c])]);

        // R4
        grant_on_want_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[c] |-> want_tas[c]);

        for (genvar k = c + 1; k < N_CPU; k++) begin : g_pair
            // R6
            tas_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(grant[c] && grant[k] && addr_a[c] == addr_a[k]));
        end
    end

endmodule

// File: rtl/semc_watch.sv
module semc_watch
    import semc_pkg::*;
#(
    parameter int N_CPU = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CPU-1:0] active,
    input  logic [N_CPU-1:0] stalled,
    input  logic [N_CPU-1:0] mask,
    input  logic             ack,
    output logic             irq,
    output logic             switch_req
);

    watch_state_e state_q, state_d;
    logic         all_wait;

    assign all_wait = (|active) && ((stalled & active) == active);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_SCAN: begin
                if (all_wait)
                    state_d = (mask == '0) ? WD_HALT : WD_YIELD;
            end
            WD_HALT: begin
                if (ack) state_d = WD_SCAN;
            end
            WD_YIELD: begin
                if (!all_wait)        state_d = WD_SCAN;
                else if (mask == '0)  state_d = WD_HALT;
            end
            default: state_d = WD_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_SCAN;
        else        state_q <= state_d;
    end

    always_comb begin
        irq        = (state_q == WD_HALT);
        switch_req = (state_q == WD_YIELD);
    end

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(all_wait) && $past(mask) == '0));

    // R11
    out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && switch_req));

    // R11
    switch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(switch_req) |-> ($past(all_wait) && $past(mask) != '0));

    // R12
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack) |=> !irq);

endmodule

// File: rtl/semc_cluster.sv
module semc_cluster #(
    parameter int N_CPU    = 4,
    parameter int N_GRP    = 8,
    parameter int GRP_SIZE = 4,
    parameter int IDX_W    = 8,
    localparam int GRP_W   = $clog2(N_GRP),
    localparam int BIT_W   = $clog2(GRP_SIZE),
    localparam int ADDR_W  = GRP_W + BIT_W,
    localparam int N_SEM   = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CPU-1:0]        cpu_active,
    input  logic [N_CPU-1:0]        req_valid,
    input  logic [2*N_CPU-1:0]      req_op,
    input  logic [N_CPU-1:0]        req_indirect,
    input  logic [N_CPU*GRP_W-1:0]  req_group,
    input  logic [N_CPU*BIT_W-1:0]  req_bit,
    input  logic [N_CPU*IDX_W-1:0]  req_index,
    input  logic [N_CPU-1:0]        switch_mask,
    input  logic                    deadlock_ack,
    output logic [N_CPU-1:0]        op_done,
    output logic [N_CPU-1:0]        stalled,
    output logic [N_SEM-1:0]        sem_state,
    output logic                    deadlock_irq,
    output logic                    switch_req
);

    logic [N_CPU-1:0]        grant, want_tas, want_set, want_clr;
    logic [N_CPU*ADDR_W-1:0] addr_flat;

    for (genvar c = 0; c < N_CPU; c++) begin : g_port
        semc_port #(
            .GRP_W (GRP_W),
            .BIT_W (BIT_W),
            .IDX_W (IDX_W)
        ) u_port (
            .clk          (clk),
            .rst_n        (rst_n),
            .active       (cpu_active[c]),
            .req_valid    (req_valid[c]),
            .req_op       (req_op[2*c +: 2]),
            .req_indirect (req_indirect[c]),
            .req_group    (req_group[c*GRP_W +: GRP_W]),
            .req_bit      (req_bit[c*BIT_W +: BIT_W]),
            .req_index    (req_index[c*IDX_W +: IDX_W]),
            .grant        (grant[c]),
            .want_tas     (want_tas[c]),
            .want_set     (want_set[c]),
            .want_clr     (want_clr[c]),
            .addr         (addr_flat[c*ADDR_W +: ADDR_W]),
            .stalled      (stalled[c]),
            .op_done      (op_done[c])
        );
    end

    semc_bank #(
        .N_CPU  (N_CPU),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .want_tas  (want_tas),
        .want_set  (want_set),
        .want_clr  (want_clr),
        .addr_flat (addr_flat),
        .grant     (grant),
        .sem_q     (sem_state)
    );

    semc_watch #(
        .N_CPU (N_CPU)
    ) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (cpu_active),
        .stalled    (stalled),
        .mask       (switch_mask),
        .ack        (deadlock_ack),
        .irq        (deadlock_irq),
        .switch_req (switch_req)
    );

endmodule

// File: tb/sim_semc_cluster.sv
module sim_semc_cluster;

    localparam logic [1:0] K_TAS = 2'b01;
    localparam logic [1:0] K_SET = 2'b10;
    localparam logic [1:0] K_CLR = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cpu_active = 4'hF;
    logic [3:0]  req_valid = '0;
    logic [7:0]  req_op = '0;
    logic [3:0]  req_indirect = '0;
    logic [11:0] req_group = '0;
    logic [7:0]  req_bit = '0;
    logic [31:0] req_index = '0;
    logic [3:0]  switch_mask = '0;
    logic        deadlock_ack = 1'b0;
    logic [3:0]  op_done, stalled;
    logic [31:0] sem_state;
    logic        deadlock_irq, switch_req;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    semc_cluster u0 (
        .clk(clk), .rst_n(rst_n), .cpu_active(cpu_active), .req_valid(req_valid),
        .req_op(req_op), .req_indirect(req_indirect), .req_group(req_group),
        .req_bit(req_bit), .req_index(req_index), .switch_mask(switch_mask),
        .deadlock_ack(deadlock_ack), .op_done(op_done), .stalled(stalled),
        .sem_state(sem_state), .deadlock_irq(deadlock_irq), .switch_req(switch_req)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_bits = '0;
    logic [3:0]  m_wait = '0, m_done = '0;
    int          m_pend [4];
    int          m_fsm = 0;   // 0 scanning, 1 interrupt, 2 switch

    function automatic int sem_num(int c);
        if (req_indirect[c]) return int'(req_index[8*c +: 8]) % 32;
        return int'(req_group[3*c +: 3]) * 4 + int'(req_bit[2*c +: 2]);
    endfunction

    function automatic bit took(int c);
        return req_valid[c] && cpu_active[c] && !m_wait[c];
    endfunction

    always @(posedge clk) begin : ref_model
        logic [31:0] nb;
        logic [3:0]  nw, nd;
        bit          allw;
        int          s;
        if (!rst_n) begin
            m_bits = '0; m_wait = '0; m_done = '0; m_fsm = 0;
            for (int c = 0; c < 4; c++) m_pend[c] = 0;
        end else begin
            allw = (cpu_active != 0) && ((m_wait & cpu_active) == cpu_active);
            nb = m_bits; nw = m_wait; nd = '0;
            for (int c = 0; c < 4; c++)
                if (took(c) && req_op[2*c +: 2] == K_CLR) begin nb[sem_num(c)] = 1'b0; nd[c] = 1'b1; end
            for (int c = 0; c < 4; c++)
                if (took(c) && req_op[2*c +: 2] == K_SET) begin nb[sem_num(c)] = 1'b1; nd[c] = 1'b1; end
            for (int c = 0; c < 4; c++) begin
                s = -1;
                if (m_wait[c]) s = m_pend[c];
                else if (took(c) && req_op[2*c +: 2] == K_TAS) s = sem_num(c);
                if (s >= 0) begin
                    if (!nb[s]) begin nb[s] = 1'b1; nd[c] = 1'b1; nw[c] = 1'b0; end
                    else begin nw[c] = 1'b1; m_pend[c] = s; end
                end
            end
            case (m_fsm)
                0: if (allw) m_fsm = (switch_mask == 0) ? 1 : 2;
                1: if (deadlock_ack) m_fsm = 0;
                default: if (!allw) m_fsm = 0; else if (switch_mask == 0) m_fsm = 1;
            endcase
            m_bits = nb; m_wait = nw; m_done = nd;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 sem_state vs model", sem_state, m_bits);
            chk("R3 op_done vs model", 32'(op_done), 32'(m_done));
            chk("R5 stalled vs model", 32'(stalled), 32'(m_wait));
            chk("R10 deadlock_irq vs model", 32'(deadlock_irq), 32'(m_fsm == 1));
            chk("R11 switch_req vs model", 32'(switch_req), 32'(m_fsm == 2));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic put(int c, logic [1:0] op, logic ind, int g, int b, int idx);
        req_valid[c]         = 1'b1;
        req_op[2*c +: 2]     = op;
        req_indirect[c]      = ind;
        req_group[3*c +: 3]  = 3'(g);
        req_bit[2*c +: 2]    = 2'(b);
        req_index[8*c +: 8]  = 8'(idx);
    endtask

    task automatic step();
        @(negedge clk);
        req_valid    = '0;
        deadlock_ack = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_err++;
            $display("FAIL watchdog R5 run hung actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 reset sem_state", sem_state, 32'h0);
        chk("R5 reset stalled", 32'(stalled), 32'h0);
        chk("R10 reset irq", 32'(deadlock_irq), 32'h0);

        // R1 / R3 direct set of group 5 bit 2 -> semaphore 22
        put(0, K_SET, 1'b0, 5, 2, 0); step();
        chk("R1 direct set bit22", 32'(sem_state[22]), 32'h1);
        chk("R3 set done pulse", 32'(op_done[0]), 32'h1);
        step();
        chk("R3 done one cycle", 32'(op_done[0]), 32'h0);

        // R2 indirect clear, index 0xF6 -> 22
        put(1, K_CLR, 1'b1, 0, 0, 8'hF6); step();
        chk("R2 indirect clear bit22", 32'(sem_state[22]), 32'h0);
        chk("R3 clear done", 32'(op_done[1]), 32'h1);

        // R4 test-and-set on clear bit 3
        put(2, K_TAS, 1'b0, 0, 3, 0); step();
        chk("R4 tas sets bit3", 32'(sem_state[3]), 32'h1);
        chk("R4 tas done", 32'(op_done[2]), 32'h1);
        chk("R4 no stall", 32'(stalled[2]), 32'h0);

        // R5 test-and-set on set bit (indirect 0x23 -> 3)
        put(3, K_TAS, 1'b1, 0, 0, 8'h23); step();
        chk("R5 stall raised", 32'(stalled[3]), 32'h1);
        chk("R5 no done while stalled", 32'(op_done[3]), 32'h0);
        repeat (3) step();
        chk("R5 stall held", 32'(stalled[3]), 32'h1);
        // R9 request at stalled port ignored
        put(3, K_CLR, 1'b0, 0, 3, 0); step();
        chk("R9 ignored clear keeps bit3", 32'(sem_state[3]), 32'h1);
        chk("R9 still stalled", 32'(stalled[3]), 32'h1);
        put(0, K_CLR, 1'b0, 0, 3, 0); step();
        chk("R5 retry wins done", 32'(op_done[3]), 32'h1);
        chk("R5 stall dropped", 32'(stalled[3]), 32'h0);
        chk("R5 bit stays set", 32'(sem_state[3]), 32'h1);
        put(3, K_CLR, 1'b0, 0, 3, 0); step();

        // R6 two ports race for bit 9
        put(1, K_TAS, 1'b0, 2, 1, 0); put(2, K_TAS, 1'b0, 2, 1, 0); step();
        chk("R6 lower port wins", 32'(op_done[1]), 32'h1);
        chk("R6 higher port stalls", 32'(stalled[2]), 32'h1);
        // R7 clear then tas same cycle; port 0 beats pending port 2
        put(1, K_CLR, 1'b0, 2, 1, 0); put(0, K_TAS, 1'b0, 2, 1, 0); step();
        chk("R7 clear-first tas wins", 32'(op_done[0]), 32'h1);
        chk("R6 pending port loses to port0", 32'(stalled[2]), 32'h1);
        put(0, K_CLR, 1'b0, 2, 1, 0); step();
        chk("R5 pending port2 acquires", 32'(op_done[2]), 32'h1);
        put(2, K_CLR, 1'b0, 2, 1, 0); step();

        // R7 set and tas same bit: tas stalls; set and clear: set wins
        put(0, K_SET, 1'b0, 3, 0, 0); put(1, K_TAS, 1'b0, 3, 0, 0);
        put(2, K_SET, 1'b0, 5, 0, 0); put(3, K_CLR, 1'b0, 5, 0, 0); step();
        chk("R7 set before tas stalls", 32'(stalled[1]), 32'h1);
        chk("R7 set beats clear bit20", 32'(sem_state[20]), 32'h1);
        put(2, K_CLR, 1'b0, 3, 0, 0); step();
        chk("R5 port1 acquires bit12", 32'(op_done[1]), 32'h1);
        put(1, K_CLR, 1'b0, 3, 0, 0); put(2, K_CLR, 1'b0, 5, 0, 0); step();

        // R8 inactive port ignored
        cpu_active = 4'b0111;
        put(3, K_SET, 1'b0, 7, 2, 0); step();
        chk("R8 inactive set ignored", 32'(sem_state[30]), 32'h0);
        chk("R8 inactive no done", 32'(op_done[3]), 32'h0);

        // R10 deadlock among active ports 0..2
        put(0, K_SET, 1'b0, 0, 0, 0); put(1, K_SET, 1'b0, 0, 1, 0); put(2, K_SET, 1'b0, 0, 2, 0); step();
        put(0, K_TAS, 1'b0, 0, 1, 0); put(1, K_TAS, 1'b0, 0, 2, 0); put(2, K_TAS, 1'b0, 0, 0, 0); step();
        chk("R5 all three stalled", 32'(stalled), 32'h7);
        chk("R10 irq not yet", 32'(deadlock_irq), 32'h0);
        step();
        chk("R10 irq raised", 32'(deadlock_irq), 32'h1);
        chk("R11 no switch with zero mask", 32'(switch_req), 32'h0);
        repeat (4) step();
        chk("R10 irq held", 32'(deadlock_irq), 32'h1);
        deadlock_ack = 1'b1; step();
        chk("R12 ack drops irq", 32'(deadlock_irq), 32'h0);
        step();
        chk("R12 irq re-raised", 32'(deadlock_irq), 32'h1);
        switch_mask = 4'b0001; step();
        chk("R10 irq held despite mask", 32'(deadlock_irq), 32'h1);
        deadlock_ack = 1'b1; step();
        chk("R12 ack drops irq again", 32'(deadlock_irq), 32'h0);
        step();
        chk("R11 switch raised", 32'(switch_req), 32'h1);
        chk("R11 no irq with mask", 32'(deadlock_irq), 32'h0);
        switch_mask = 4'b0000; step();
        chk("R11 hand over to irq", 32'(deadlock_irq), 32'h1);
        chk("R11 switch dropped", 32'(switch_req), 32'h0);
        switch_mask = 4'b0010; deadlock_ack = 1'b1; step(); step();
        chk("R11 switch again", 32'(switch_req), 32'h1);
        cpu_active = 4'hF; step();
        chk("R8 idle active port breaks condition", 32'(switch_req), 32'h0);
        put(3, K_CLR, 1'b0, 0, 1, 0); step();
        chk("R5 port0 released", 32'(op_done[0]), 32'h1);
        put(3, K_CLR, 1'b0, 0, 2, 0); step();
        put(3, K_CLR, 1'b0, 0, 0, 0); step();
        chk("R5 port2 released", 32'(op_done[2]), 32'h1);
        chk("R5 none stalled", 32'(stalled), 32'h0);

        // R8 no active port: no watchdog action
        cpu_active = 4'h0; switch_mask = 4'h0;
        repeat (3) step();
        chk("R8 no active no irq", 32'(deadlock_irq), 32'h0);
        chk("R8 no active no switch", 32'(switch_req), 32'h0);

        finished = 1;
        summary();
        $finish;
    end

endmodule